// File: doc/BRIEF.md
# Coincidence Trigger and Prescaler Unit

This block turns per-channel digitized amplitudes from two detector sides (left and right), each with four calorimeter channels and eight scintillator channels, into hit signals and coincidence terms. A side's calorimeter hit compares the sum of its four channels against a programmable threshold. A side's scintillator hit is the OR of four pair tests, each on the sum of two adjacent channels. Each raw hit is stretched to a programmable fixed width. The stretched hits then form five coincidence terms that feed external scalers. One of those terms uses a copy of the scintillator coincidence delayed by a programmable number of cycles.

Three trigger conditions (both calorimeters, left calorimeter alone, right calorimeter alone) each pass through their own prescaler. A trigger fires only while the downstream ready input is high. Each trigger opens a capture window that collects every prescaled condition passing in it. At the end of the window the block emits a pattern word that also carries the helicity sampled at the trigger. A low acquisition enable silences all outputs and clears the internal state.

Top module: `coinc_trig_unit`

## Requirements
- R1: A side's calorimeter raw hit is high in a cycle when the unsigned sum of its four calorimeter channels is strictly greater than `cal_thr_i`. A sum equal to the threshold gives no hit.
- R2: A side's scintillator raw hit is high when any of its four pairs, channels {0,1}, {2,3}, {4,5} or {6,7}, has an unsigned sum strictly greater than `sci_thr_i`.
- R3: The input sampled at a clock edge where a raw hit goes from low to high starts a stretched hit. The stretched hit is high for exactly `stretch_len_i` cycles, beginning in the cycle after that edge; a length of 0 acts as 1. A new rising raw hit reloads the full length.
- R4: `coinc_o` is registered from the stretched hits one edge after they change. Bit 0 is CL&CR, bit 1 is CL&SL, bit 2 is CR&SR and bit 3 is CL&CR&SL&SR, where CL/CR are the calorimeter hits and SL/SR the scintillator hits of the left and right sides.
- R5: `coinc_o[4]` is CL&CR combined with SL&SR taken D cycles earlier, where D is `dly_len_i`. A value of 0 acts as 1 and values above 32 act as 32.
- R6: Each trigger condition (bit 0 CL&CR, bit 1 CL, bit 2 CR) counts its rising edges. Its prescaler passes the Nth, 2Nth, ... edge for factor N; factors 0 and 1 pass every edge. The count advances whether or not the trigger is ready.
- R7: When no window is open, a cycle with at least one passing condition while `trig_rdy_i` is high makes `trig_o` high for exactly the next cycle. Passes while `trig_rdy_i` is low are dropped.
- R8: A trigger opens an 8-cycle window starting at its pass cycle. No new trigger can start during it. `trig_word_vld_o` is high for one cycle right after the window. `trig_word_o` is then {helicity at the trigger cycle (bit 3), OR of all condition passes in the window (bits 2:0, same order as R6)}.
- R9: In the cycle after any edge with `acq_en_i` low, all outputs are 0. That edge clears all stretchers, the delay line, prescaler counts and any open window.
- R10: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acq_en_i | input | 1 | Acquisition enable |
| cal_l_i | input | 48 | Left calorimeter channels, channel k at bits 12k+11:12k |
| cal_r_i | input | 48 | Right calorimeter channels |
| sci_l_i | input | 96 | Left scintillator channels, channel k at bits 12k+11:12k |
| sci_r_i | input | 96 | Right scintillator channels |
| cal_thr_i | input | 14 | Calorimeter sum threshold |
| sci_thr_i | input | 13 | Scintillator pair sum threshold |
| stretch_len_i | input | 4 | Stretched hit width in cycles |
| dly_len_i | input | 6 | Delay of the SL&SR copy in cycles |
| ps_lr_i | input | 10 | Prescale factor of CL&CR |
| ps_l_i | input | 10 | Prescale factor of CL |
| ps_r_i | input | 10 | Prescale factor of CR |
| helicity_i | input | 1 | Helicity state |
| trig_rdy_i | input | 1 | Downstream ready for a trigger |
| coinc_o | output | 5 | Coincidence terms |
| trig_o | output | 1 | Trigger pulse |
| trig_word_vld_o | output | 1 | Pattern word valid |
| trig_word_o | output | 4 | Helicity and trigger pattern |

## Verification
A stretcher holding a stale count shows within one cycle as a coincidence bit staying high too long, or not long enough. A wrong delay tap shows only on bit 4, and only when the scintillator and calorimeter pulses overlap at the shifted time. Prescaler count errors show as a trigger early or late, by whole condition edges. A window counter that is off by one moves the valid pulse by a cycle, or lets a pass in the last slot escape the pattern. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported in the cycle it first appears.

// File: rtl/coinc_trig_pkg.sv
package coinc_trig_pkg;
  localparam int unsigned N_CAL     = 4;
  localparam int unsigned N_SCI     = 8;
  localparam int unsigned N_HIT     = 4;  // CL, CR, SL, SR
  localparam int unsigned N_COND    = 3;  // CL&CR, CL, CR
  localparam int unsigned N_COINC   = 5;

  typedef enum int unsigned {
    HIT_CL = 0,
    HIT_CR = 1,
    HIT_SL = 2,
    HIT_SR = 3
  } hit_idx_e;

  typedef struct packed {
    logic sci;
    logic cal;
  } side_hit_t;
endpackage

// File: rtl/ct_side_hit.sv
module ct_side_hit
  import coinc_trig_pkg::*;
#(
  parameter int unsigned ADC_W = 12,
  localparam int unsigned CAL_SW  = ADC_W + $clog2(N_CAL),
  localparam int unsigned PAIR_SW = ADC_W + 1
) (
  input  logic [N_CAL*ADC_W-1:0] cal_i,
  input  logic [N_SCI*ADC_W-1:0] sci_i,
  input  logic [CAL_SW-1:0]      cal_thr_i,
  input  logic [PAIR_SW-1:0]     sci_thr_i,
  output side_hit_t              raw_o
);
  localparam int unsigned N_PAIR = N_SCI / 2;

  logic [CAL_SW-1:0] cal_sum;
  logic [N_PAIR-1:0] pair_hit;

  always_comb begin
    cal_sum = '0;
    for (int i = 0; i < N_CAL; i++) begin
      cal_sum = cal_sum + CAL_SW'(cal_i[i*ADC_W +: ADC_W]);
    end
  end

  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    logic [PAIR_SW-1:0] pair_sum;
    assign pair_sum = {1'b0, sci_i[(2*p)*ADC_W +: ADC_W]}
                    + {1'b0, sci_i[(2*p+1)*ADC_W +: ADC_W]};
    assign pair_hit[p] = pair_sum > sci_thr_i;
  end

  assign raw_o.cal = cal_sum > cal_thr_i;
  assign raw_o.sci = |pair_hit;
endmodule

// File: rtl/ct_stretch.sv
module ct_stretch #(
  parameter int unsigned STR_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             raw_i,
  input  logic [STR_W-1:0] len_i,
  output logic             hit_o
);
  logic             raw_q;
  logic [STR_W-1:0] cnt_q;
  logic             rise;
  logic [STR_W-1:0] load_val;

  assign rise     = raw_i & ~raw_q;
  assign load_val = (len_i == '0) ? STR_W'(1) : len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= 1'b0;
      cnt_q <= '0;
    end else if (clr_i) begin
      raw_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      raw_q <= raw_i;
      if (rise)               cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end
  end

  assign hit_o = cnt_q != '0;

  // a stretched hit only starts after a sampled raw hit
  p_stretch_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hit_o) |-> $past(raw_i));
endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int unsigned PS_W = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            cond_i,
  input  logic [PS_W-1:0] factor_i,
  output logic            pass_o
);
  logic            cond_q;
  logic [PS_W-1:0] cnt_q;
  logic            edge_s;
  logic            last;

  assign edge_s = cond_i & ~cond_q;
  assign last   = (factor_i <= PS_W'(1)) || (cnt_q >= factor_i - 1'b1);
  assign pass_o = edge_s & last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cond_q <= 1'b0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      cond_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      cond_q <= cond_i;
      if (edge_s) cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  // edge based: never passes two cycles in a row
  p_pass_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_o |=> !pass_o);
endmodule

// File: rtl/ct_trig_win.sv
module ct_trig_win #(
  parameter int unsigned NC      = 3,
  parameter int unsigned WIN_LEN = 8,  // >= 2
  localparam int unsigned CW = $clog2(WIN_LEN + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic [NC-1:0] pass_i,
  input  logic          rdy_i,
  input  logic          hel_i,
  output logic          trig_o,
  output logic          word_vld_o,
  output logic [NC:0]   word_o
);
  logic [CW-1:0] win_q;
  logic [NC-1:0] pat_q;
  logic          hel_q;
  logic          start;

  assign start = (win_q == '0) && (|pass_i) && rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= '0;
      pat_q      <= '0;
      hel_q      <= 1'b0;
      trig_o     <= 1'b0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else if (clr_i) begin
      win_q      <= '0;
      pat_q      <= '0;
      hel_q      <= 1'b0;
      trig_o     <= 1'b0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      trig_o     <= start;
      word_vld_o <= 1'b0;
      if (start) begin
        win_q <= CW'(WIN_LEN - 1);
        pat_q <= pass_i;
        hel_q <= hel_i;
      end else if (win_q != '0) begin
        pat_q <= pat_q | pass_i;
        win_q <= win_q - 1'b1;
        if (win_q == CW'(1)) begin
          word_vld_o <= 1'b1;
          word_o     <= {hel_q, pat_q | pass_i};
        end
      end
    end
  end

  p_trig_rdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> $past(rdy_i));
  p_trig_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !trig_o);
  p_word_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_vld_o |=> !word_vld_o);
  p_word_after_trig_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |=> !word_vld_o);
endmodule

// File: rtl/coinc_trig_unit.sv
module coinc_trig_unit
  import coinc_trig_pkg::*;
#(
  parameter int unsigned ADC_W     = 12,
  parameter int unsigned STR_W     = 4,
  parameter int unsigned DLY_DEPTH = 32,
  parameter int unsigned PS_W      = 10,
  parameter int unsigned WIN_LEN   = 8,
  localparam int unsigned CAL_SW  = ADC_W + $clog2(N_CAL),
  localparam int unsigned PAIR_SW = ADC_W + 1,
  localparam int unsigned DLY_LW  = $clog2(DLY_DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   acq_en_i,
  input  logic [N_CAL*ADC_W-1:0] cal_l_i,
  input  logic [N_CAL*ADC_W-1:0] cal_r_i,
  input  logic [N_SCI*ADC_W-1:0] sci_l_i,
  input  logic [N_SCI*ADC_W-1:0] sci_r_i,
  input  logic [CAL_SW-1:0]      cal_thr_i,
  input  logic [PAIR_SW-1:0]     sci_thr_i,
  input  logic [STR_W-1:0]       stretch_len_i,
  input  logic [DLY_LW-1:0]      dly_len_i,
  input  logic [PS_W-1:0]        ps_lr_i,
  input  logic [PS_W-1:0]        ps_l_i,
  input  logic [PS_W-1:0]        ps_r_i,
  input  logic                   helicity_i,
  input  logic                   trig_rdy_i,
  output logic [N_COINC-1:0]     coinc_o,
  output logic                   trig_o,
  output logic                   trig_word_vld_o,
  output logic [N_COND:0]        trig_word_o
);
  localparam int unsigned IDX_W = $clog2(DLY_DEPTH);

  logic                 clr;
  side_hit_t            raw_l, raw_r;
  logic [N_HIT-1:0]     raw_vec;
  logic [N_HIT-1:0]     hit;
  logic [DLY_DEPTH-1:0] pipe_q;
  logic [IDX_W-1:0]     tap_idx;
  logic                 sl_sr_dly;
  logic [N_COND-1:0]    cond;
  logic [N_COND-1:0]    pass;
  logic [PS_W-1:0]      ps_factor [N_COND];

  assign clr = ~acq_en_i;

  ct_side_hit #(.ADC_W(ADC_W)) i_side_l (
    .cal_i(cal_l_i), .sci_i(sci_l_i),
    .cal_thr_i(cal_thr_i), .sci_thr_i(sci_thr_i), .raw_o(raw_l)
  );
  ct_side_hit #(.ADC_W(ADC_W)) i_side_r (
    .cal_i(cal_r_i), .sci_i(sci_r_i),
    .cal_thr_i(cal_thr_i), .sci_thr_i(sci_thr_i), .raw_o(raw_r)
  );

  assign raw_vec[HIT_CL] = raw_l.cal;
  assign raw_vec[HIT_CR] = raw_r.cal;
  assign raw_vec[HIT_SL] = raw_l.sci;
  assign raw_vec[HIT_SR] = raw_r.sci;

  for (genvar h = 0; h < N_HIT; h++) begin : g_str
    ct_stretch #(.STR_W(STR_W)) i_str (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .raw_i(raw_vec[h]), .len_i(stretch_len_i), .hit_o(hit[h])
    );
  end

  // delayed scintillator coincidence
  always_comb begin
    if (dly_len_i == '0)                      tap_idx = '0;
    else if (dly_len_i > DLY_LW'(DLY_DEPTH))  tap_idx = IDX_W'(DLY_DEPTH - 1);
    else                                      tap_idx = IDX_W'(dly_len_i - 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  pipe_q <= '0;
    else if (clr) pipe_q <= '0;
    else          pipe_q <= {pipe_q[DLY_DEPTH-2:0], hit[HIT_SL] & hit[HIT_SR]};
  end

  assign sl_sr_dly = pipe_q[tap_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coinc_o <= '0;
    end else if (clr) begin
      coinc_o <= '0;
    end else begin
      coinc_o[0] <= hit[HIT_CL] & hit[HIT_CR];
      coinc_o[1] <= hit[HIT_CL] & hit[HIT_SL];
      coinc_o[2] <= hit[HIT_CR] & hit[HIT_SR];
      coinc_o[3] <= &hit;
      coinc_o[4] <= hit[HIT_CL] & hit[HIT_CR] & sl_sr_dly;
    end
  end

  // trigger conditions and prescalers
  assign cond[0] = hit[HIT_CL] & hit[HIT_CR];
  assign cond[1] = hit[HIT_CL];
  assign cond[2] = hit[HIT_CR];

  assign ps_factor[0] = ps_lr_i;
  assign ps_factor[1] = ps_l_i;
  assign ps_factor[2] = ps_r_i;

  for (genvar c = 0; c < N_COND; c++) begin : g_ps
    ct_prescale #(.PS_W(PS_W)) i_ps (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
      .cond_i(cond[c]), .factor_i(ps_factor[c]), .pass_o(pass[c])
    );
  end

  ct_trig_win #(.NC(N_COND), .WIN_LEN(WIN_LEN)) i_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr),
    .pass_i(pass), .rdy_i(trig_rdy_i), .hel_i(helicity_i),
    .trig_o(trig_o), .word_vld_o(trig_word_vld_o), .word_o(trig_word_o)
  );

  p_coinc_off_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(acq_en_i) |-> (coinc_o == '0 && !trig_o && !trig_word_vld_o));
  p_coinc_nest_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coinc_o[3] |-> (coinc_o[1] && coinc_o[2] && coinc_o[0]));
  p_dly_needs_lr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coinc_o[4] |-> coinc_o[0]);
endmodule

// File: tb/test_coinc_trig_unit.sv
module test_coinc_trig_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        acq_en_i = 1'b0;
  logic [47:0] cal_l_i = '0, cal_r_i = '0;
  logic [95:0] sci_l_i = '0, sci_r_i = '0;
  logic [13:0] cal_thr_i = 14'd100;
  logic [12:0] sci_thr_i = 13'd50;
  logic [3:0]  stretch_len_i = 4'd3;
  logic [5:0]  dly_len_i = 6'd1;
  logic [9:0]  ps_lr_i = 10'd1, ps_l_i = 10'd1, ps_r_i = 10'd1;
  logic        helicity_i = 1'b0;
  logic        trig_rdy_i = 1'b1;
  logic [4:0]  coinc_o;
  logic        trig_o, trig_word_vld_o;
  logic [3:0]  trig_word_o;

  coinc_trig_unit i_coinc_trig_unit (.*);

  always #10 clk_i = ~clk_i;

  int    n_chk = 0, n_bad = 0, cyc = 0;
  string phase = "R10";

  // reference model state
  int       m_cnt [4];
  bit       m_rawq [4];
  bit       m_pipe [32];
  bit       m_condq [3];
  int       m_ps [3];
  int       m_win;
  bit [2:0] m_pat;
  bit       m_hel;
  bit [4:0] e_coinc = '0;
  bit       e_trig = 0, e_vld = 0;
  bit [3:0] e_word = '0;
  bit       e_acq_off = 1;

  function automatic int csum(input logic [47:0] v);
    int s = 0;
    for (int i = 0; i < 4; i++) s += int'(v[i*12 +: 12]);
    return s;
  endfunction

  function automatic bit shit(input logic [95:0] v, input int thr);
    bit h = 0;
    for (int p = 0; p < 4; p++)
      if (int'(v[(2*p)*12 +: 12]) + int'(v[(2*p+1)*12 +: 12]) > thr) h = 1;
    return h;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin m_cnt[i] = 0; m_rawq[i] = 0; end
    for (int i = 0; i < 32; i++) m_pipe[i] = 0;
    for (int i = 0; i < 3; i++) begin m_condq[i] = 0; m_ps[i] = 0; end
    m_win = 0; m_pat = '0; m_hel = 0;
    e_coinc = '0; e_trig = 0; e_vld = 0;
  endtask

  always @(posedge clk_i) begin
    bit raw [4];
    bit h [4];
    bit c [3];
    bit [2:0] pass;
    int idx, eff, len;
    if (!rst_ni) begin
      model_clear();
      e_acq_off = 1;
    end else if (!acq_en_i) begin
      model_clear();
      e_acq_off = 1;
    end else begin
      e_acq_off = 0;
      raw[0] = csum(cal_l_i) > int'(cal_thr_i);
      raw[1] = csum(cal_r_i) > int'(cal_thr_i);
      raw[2] = shit(sci_l_i, int'(sci_thr_i));
      raw[3] = shit(sci_r_i, int'(sci_thr_i));
      for (int i = 0; i < 4; i++) h[i] = m_cnt[i] > 0;
      idx = (dly_len_i == 0) ? 0 : (dly_len_i > 32) ? 31 : int'(dly_len_i) - 1;
      e_coinc = {h[0] & h[1] & m_pipe[idx], h[0] & h[1] & h[2] & h[3],
                 h[1] & h[3], h[0] & h[2], h[0] & h[1]};
      for (int i = 31; i > 0; i--) m_pipe[i] = m_pipe[i-1];
      m_pipe[0] = h[2] & h[3];
      len = (stretch_len_i == 0) ? 1 : int'(stretch_len_i);
      for (int i = 0; i < 4; i++) begin
        if (raw[i] && !m_rawq[i]) m_cnt[i] = len;
        else if (m_cnt[i] > 0)    m_cnt[i]--;
        m_rawq[i] = raw[i];
      end
      c[0] = h[0] & h[1]; c[1] = h[0]; c[2] = h[1];
      for (int k = 0; k < 3; k++) begin
        eff = (k == 0) ? int'(ps_lr_i) : (k == 1) ? int'(ps_l_i) : int'(ps_r_i);
        if (eff == 0) eff = 1;
        pass[k] = 0;
        if (c[k] && !m_condq[k]) begin
          if (m_ps[k] >= eff - 1) begin pass[k] = 1; m_ps[k] = 0; end
          else m_ps[k]++;
        end
        m_condq[k] = c[k];
      end
      e_vld = 0;
      e_trig = (m_win == 0) && (pass != 0) && trig_rdy_i;
      if (e_trig) begin
        m_win = 7; m_pat = pass; m_hel = helicity_i;
      end else if (m_win > 0) begin
        if (m_win == 1) begin e_vld = 1; e_word = {m_hel, m_pat | pass}; end
        m_pat |= pass;
        m_win--;
      end
    end
  end

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s phase=%s cyc=%0d got=%0h exp=%0h", req, what, phase, cyc, got, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (!rst_ni) begin
      chk("R10", "coinc", int'(coinc_o), 0);
      chk("R10", "trig", int'(trig_o), 0);
      chk("R10", "vld", int'(trig_word_vld_o), 0);
    end else if (e_acq_off) begin
      chk("R9", "coinc", int'(coinc_o), 0);
      chk("R9", "trig", int'(trig_o), 0);
      chk("R9", "vld", int'(trig_word_vld_o), 0);
    end else begin
      chk("R4", "coinc[3:0]", int'(coinc_o[3:0]), int'(e_coinc[3:0]));
      chk("R5", "coinc[4]", int'(coinc_o[4]), int'(e_coinc[4]));
      chk("R7", "trig", int'(trig_o), int'(e_trig));
      chk("R8", "vld", int'(trig_word_vld_o), int'(e_vld));
      if (e_vld) chk("R8", "word", int'(trig_word_o), int'(e_word));
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic hits(input bit cl, input bit cr, input bit sl, input bit sr);
    cal_l_i = cl ? {4{12'd40}} : '0;
    cal_r_i = cr ? {4{12'd40}} : '0;
    sci_l_i = sl ? {{6{12'd0}}, 12'd30, 12'd30} : '0;
    sci_r_i = sr ? {12'd30, 12'd30, {6{12'd0}}} : '0;
  endtask

  task automatic pulse(input bit cl, input bit cr, input bit sl, input bit sr,
                       input int on, input int off);
    hits(cl, cr, sl, sr); step(on);
    hits(0, 0, 0, 0);     step(off);
  endtask

  initial begin
    step(4);
    rst_ni = 1'b1;
    step(2);
    acq_en_i = 1'b1;
    step(2);

    phase = "R1";
    cal_l_i = {4{12'd25}}; cal_r_i = {4{12'd25}}; step(6);   // equal: no hit
    cal_l_i = {12'd26, {3{12'd25}}}; step(2);
    cal_r_i = {12'd0, 12'd0, 12'd0, 12'd101}; step(6);
    hits(0, 0, 0, 0); step(6);

    phase = "R2";
    for (int p = 0; p < 4; p++) begin
      sci_l_i = '0; sci_r_i = '0;
      sci_l_i[(2*p)*12 +: 24] = {12'd25, 12'd25}; step(3);    // 50: no hit
      sci_l_i[(2*p)*12 +: 12] = 12'd26;
      sci_r_i[(2*p+1)*12 +: 12] = 12'd51;
      hits(1, 1, 0, 0);
      sci_l_i[(2*p)*12 +: 24] = {12'd25, 12'd26};
      sci_r_i[(2*p+1)*12 +: 12] = 12'd51;
      step(4);
      hits(0, 0, 0, 0); step(5);
    end

    phase = "R3";
    for (int l = 0; l < 6; l++) begin
      stretch_len_i = 4'(l * 3);
      pulse(1, 1, 1, 1, 1, 20);
      pulse(1, 0, 1, 0, 2, 1);
      pulse(1, 0, 1, 0, 1, 20);
    end
    stretch_len_i = 4'd4;

    phase = "R5";
    foreach (dly_len_i[i]) ;
    for (int d = 0; d < 6; d++) begin
      dly_len_i = (d == 5) ? 6'd40 : 6'(d * 7);
      hits(0, 0, 1, 1); step(2); hits(0, 0, 0, 0);
      for (int w = 0; w < 40; w++) begin
        hits(w % 3 == 0, w % 3 == 0, 0, 0); step(1);
      end
      hits(0, 0, 0, 0); step(40);
    end
    dly_len_i = 6'd2;

    phase = "R6";
    ps_lr_i = 10'd3; ps_l_i = 10'd0; ps_r_i = 10'd5;
    for (int i = 0; i < 12; i++) pulse(1, i % 2, 0, 0, 2, 10);
    ps_lr_i = 10'd1000; ps_l_i = 10'd2; ps_r_i = 10'd1;
    for (int i = 0; i < 8; i++) pulse(i % 3 != 0, 1, 0, 0, 1, 12);

    phase = "R7";
    ps_lr_i = 10'd1; ps_l_i = 10'd1; ps_r_i = 10'd1;
    for (int i = 0; i < 10; i++) begin
      trig_rdy_i = (i % 3 != 1);
      pulse(1, 0, 0, 0, 1, 12);
    end
    trig_rdy_i = 1'b1;

    phase = "R8";
    for (int g = 1; g < 10; g++) begin
      helicity_i = ~helicity_i;
      hits(1, 0, 0, 0); step(1);
      helicity_i = ~helicity_i;
      hits(0, 0, 0, 0); step(g);
      hits(0, 1, 0, 0); step(1);
      hits(0, 0, 0, 0); step(g);
      hits(1, 1, 0, 0); step(1);
      hits(0, 0, 0, 0); step(15);
    end

    phase = "R9";
    for (int i = 0; i < 6; i++) begin
      hits(1, 1, 1, 1); step(2 + i);
      acq_en_i = 1'b0; step(1 + (i % 2));
      acq_en_i = 1'b1; step(3);
      hits(0, 0, 0, 0); step(12);
    end

    phase = "RND";
    for (int i = 0; i < 4000; i++) begin
      if (i % 250 == 0) begin
        stretch_len_i = 4'($urandom_range(0, 6));
        dly_len_i = 6'($urandom_range(0, 40));
        ps_lr_i = 10'($urandom_range(0, 4));
        ps_l_i = 10'($urandom_range(0, 4));
        ps_r_i = 10'($urandom_range(0, 4));
      end
      for (int k = 0; k < 4; k++) begin
        cal_l_i[k*12 +: 12] = 12'($urandom_range(0, 45));
        cal_r_i[k*12 +: 12] = 12'($urandom_range(0, 45));
      end
      for (int k = 0; k < 8; k++) begin
        sci_l_i[k*12 +: 12] = 12'($urandom_range(0, 28));
        sci_r_i[k*12 +: 12] = 12'($urandom_range(0, 28));
      end
      helicity_i = 1'($urandom_range(0, 1));
      trig_rdy_i = ($urandom_range(0, 9) != 0);
      acq_en_i = ($urandom_range(0, 99) != 0);
      step(1);
    end
    acq_en_i = 1'b1;
    hits(0, 0, 0, 0);
    step(20);

    phase = "R10";
    rst_ni = 1'b0; step(3);
    rst_ni = 1'b1; step(2);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule